// File: doc/BRIEF.md
# Distributed Multiprocessor Bus Arbiter

Up to six identical processors and one host share one external bus. Each processor holds a copy of this block. Every copy drives a single request line of its own and watches all six lines. The line a copy drives is chosen by a small identifier that is captured while reset is held. All copies sample the same inputs on the same clock edge and apply the same rule, so every copy holds the same view of the current master. Only the copy whose identifier matches that master enables its address, data, select and strobe drivers.

The priority rule is picked by a live input, which may change only on an edge that all copies share. In fixed mode the lowest identifier wins, and a waiting lower identifier takes the bus when the current bus cycle ends. In rotating mode the search begins at the identifier after the most recent master and wraps from six to one. A master is never displaced mid-cycle. At the end of its cycle it gives way to a host request, to a processor that raises the shared core-priority line, or to a higher-priority request in fixed mode. It also gives way if it has stopped requesting.

A host request always wins. The master finishes its cycle and floats the bus for one cycle. The host grant is then raised and held until the host withdraws. A suspend input floats the bus outputs in the following cycle and stalls an owned access for as long as it lasts. With identifier zero the block runs alone: no arbitration takes place, and it owns the bus whenever the host does not.

Top module: `mp_bus_arbiter`

The controller has four states:
- `ST_IDLE`: no owner.
- `ST_BUSY`: a processor owns the bus.
- `ST_HREL`: one-cycle float before the host takes the bus.
- `ST_HOST`: the host is granted.

The transitions are:
- idle or host to host while the host requests.
- idle or host to busy on a winning request, or at once when running alone.
- busy to release when the bus cycle ends with the host requesting.
- busy to busy when the bus is handed to a new winner.
- busy to idle when no one requests at handoff.
- release to host, unconditionally.

## Requirements
- R1: Reset is synchronous and active-low. In the first cycle after reset the state is idle, and `bus_oe`, `host_grant`, `is_master` and `access_stall` are all 0.
- R2: Processor ID k (1..6) corresponds to bit k-1 of `br_in`. `br_out` equals `core_req` when the ID is 1..6 and is 0 when the ID is 0. The bit of `br_in` that belongs to the copy's own ID is ignored and replaced by `br_out`.
- R3: When a bus is given from idle, from the host state or at a handoff, the winner is chosen as follows. In fixed mode (`cfg_rotate`=0) the lowest requesting ID wins. In rotating mode the search starts at the ID after the most recent master and wraps from 6 to 1. The outgoing master is excluded from the choice at a handoff.
- R4: While `bus_cyc_end` is 0 the master does not change. In fixed mode, when `bus_cyc_end` is 1 and a lower ID is requesting, the bus passes to a new master on the next cycle. In rotating mode, a request from a lower ID alone never displaces the master.
- R5: A host request to a busy bus takes effect only when `bus_cyc_end` is 1. After that edge there is one cycle with `bus_oe`=0 and `host_grant`=0. `host_grant` then rises and stays 1 for as long as `host_req` is 1. From idle, the grant follows after one edge.
- R6: When `cpa_in` is 1 and `bus_cyc_end` is 1, the master gives up the bus to the next winner, chosen among the other requesters.
- R7: When `suspend` is sampled 1, `bus_oe` is 0 in the next cycle. If this copy owns the bus and `core_req` is 1 in that cycle, `access_stall` is 1.
- R8: With ID 0, the block is master whenever the state is busy. It enters that state one edge after reset, or one edge after the host releases. It leaves it only for the host.
- R9: `cfg_id` is captured only while reset is asserted. Later changes to it have no effect.
- R10: `cpa_out` is 1 exactly when the ID is 1..6, `core_req` and `core_prio` are both 1, and this copy is not the master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_id | input | 3 | Processor identifier, captured during reset |
| cfg_rotate | input | 1 | 1 = rotating priority, 0 = fixed |
| core_req | input | 1 | This processor wants the external bus |
| core_prio | input | 1 | The request comes from the core, not background DMA |
| br_in | input | 6 | Observed request lines, bit k-1 = ID k |
| br_out | output | 1 | Drive for this copy's own request line |
| cpa_in | input | 1 | Observed shared core-priority line, active high |
| cpa_out | output | 1 | Drive onto the shared core-priority line |
| host_req | input | 1 | Host bus request, active high |
| host_grant | output | 1 | Host bus grant, active high |
| suspend | input | 1 | Float bus outputs in the next cycle |
| bus_cyc_end | input | 1 | The current external bus cycle completes this cycle |
| bus_oe | output | 1 | Enable for address, data, select and strobe drivers |
| is_master | output | 1 | This copy owns the bus |
| access_stall | output | 1 | The owned access is held off by suspend |

## Verification
The bench builds the block with its default widths: six processors and a 3-bit identifier. The bench itself plays the other five processors. It resets the block several times with different identifiers and modes:
- ID 3 with fixed and with rotating priority, which covers preemption both above and below this copy.
- ID 6 in rotating mode, which reaches the wrap from six to one.
- ID 1, which can never be preempted under fixed priority.
- ID 0, for the single-processor path.

Random changes to `cfg_id` after reset, and random values on this copy's own `br_in` bit, exercise the inputs that must be ignored.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_HREL = 2'd2,
        ST_HOST = 2'd3
    } arb_state_e;

endpackage

// File: rtl/mpa_cfg_latch.sv
module mpa_cfg_latch #(
    parameter int NPROC = 6,
    parameter int IDW   = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [IDW-1:0] cfg_id,
    output logic [IDW-1:0] id_q,
    output logic           id_valid
);

    // Identifier is loaded on every edge while reset is held, then frozen.
    always_ff @(posedge clk) begin
        if (!rst_n) id_q <= cfg_id;
    end

    assign id_valid = (id_q != '0) && (id_q <= IDW'(NPROC));

    assert_id_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(id_q));

endmodule

// File: rtl/mpa_pick.sv
module mpa_pick #(
    parameter int NPROC = 6,
    parameter int IDW   = 3
) (
    input  logic [NPROC-1:0] req,
    input  logic [IDW-1:0]   start_id,
    output logic [IDW-1:0]   win
);

    localparam int SW = (NPROC > 1) ? $clog2(NPROC) : 1;

    int idx;

    // Scan from the farthest slot back to the start slot; the last hit wins,
    // so the first requester at or after start_id (modulo NPROC) is chosen.
    always_comb begin
        win = '0;
        idx = 0;
        for (int k = NPROC - 1; k >= 0; k--) begin
            idx = (int'(start_id) + k) % NPROC;
            if (req[SW'(idx)]) win = IDW'(idx + 1);
        end
    end

endmodule

// File: rtl/mpa_drive.sv
module mpa_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic suspend,
    input  logic own_turn,
    input  logic core_req,
    output logic bus_oe,
    output logic access_stall
);

    logic susp_q;

    always_ff @(posedge clk) begin
        if (!rst_n) susp_q <= 1'b0;
        else        susp_q <= suspend;
    end

    assign bus_oe       = own_turn && !susp_q;
    assign access_stall = own_turn && core_req && susp_q;

    assert_suspend_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |=> !bus_oe);

endmodule

// File: rtl/mp_bus_arbiter.sv
module mp_bus_arbiter
    import mpa_pkg::*;
#(
    parameter int NPROC = 6,
    parameter int IDW   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDW-1:0]   cfg_id,
    input  logic             cfg_rotate,
    input  logic             core_req,
    input  logic             core_prio,
    input  logic [NPROC-1:0] br_in,
    output logic             br_out,
    input  logic             cpa_in,
    output logic             cpa_out,
    input  logic             host_req,
    output logic             host_grant,
    input  logic             suspend,
    input  logic             bus_cyc_end,
    output logic             bus_oe,
    output logic             is_master,
    output logic             access_stall
);

    arb_state_e       state_q, state_d;
    logic [IDW-1:0]   master_q, master_d;
    logic [IDW-1:0]   last_q, last_d;
    logic [IDW-1:0]   id_q;
    logic             id_valid;
    logic             solo;
    logic [NPROC-1:0] req_v, mbit, lower, req_pick;
    logic [IDW-1:0]   win, start_id;
    logic             drop, outranked;

    mpa_cfg_latch #(.NPROC(NPROC), .IDW(IDW)) i_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_id(cfg_id),
        .id_q(id_q), .id_valid(id_valid)
    );

    assign solo   = !id_valid;
    assign br_out = id_valid && core_req;

    // Request view: own line replaced by own drive; masks relative to master.
    always_comb begin
        for (int i = 0; i < NPROC; i++) begin
            req_v[i] = (id_valid && id_q == IDW'(i + 1)) ? br_out : br_in[i];
            mbit[i]  = (master_q == IDW'(i + 1));
            lower[i] = (IDW'(i + 1) < master_q);
        end
    end

    assign req_pick  = req_v & ~mbit;
    assign start_id  = cfg_rotate ? last_q : '0;
    assign drop      = !(|(req_v & mbit));
    assign outranked = !cfg_rotate && (|(req_v & lower));

    mpa_pick #(.NPROC(NPROC), .IDW(IDW)) i_pick (
        .req(req_pick), .start_id(start_id), .win(win)
    );

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        master_d = master_q;
        last_d   = last_q;
        unique case (state_q)
            ST_IDLE, ST_HOST: begin
                if (host_req) begin
                    state_d = ST_HOST;
                end else if (solo) begin
                    state_d = ST_BUSY;
                end else if (win != '0) begin
                    state_d  = ST_BUSY;
                    master_d = win;
                    last_d   = win;
                end else begin
                    state_d  = ST_IDLE;
                    master_d = '0;
                end
            end
            ST_BUSY: begin
                if (bus_cyc_end) begin
                    if (host_req) begin
                        state_d  = ST_HREL;
                        master_d = '0;
                    end else if (!solo && (drop || outranked || cpa_in)) begin
                        if (win != '0) begin
                            master_d = win;
                            last_d   = win;
                        end else begin
                            state_d  = ST_IDLE;
                            master_d = '0;
                        end
                    end
                end
            end
            ST_HREL: state_d = ST_HOST;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            master_q <= '0;
            last_q   <= '0;
        end else begin
            state_q  <= state_d;
            master_q <= master_d;
            last_q   <= last_d;
        end
    end

    // Outputs
    always_comb begin
        host_grant = (state_q == ST_HOST);
        is_master  = (state_q == ST_BUSY) && (solo || master_q == id_q);
        cpa_out    = id_valid && core_req && core_prio && !is_master;
    end

    mpa_drive i_drive (
        .clk(clk), .rst_n(rst_n), .suspend(suspend),
        .own_turn(is_master), .core_req(core_req),
        .bus_oe(bus_oe), .access_stall(access_stall)
    );

    assert_grant_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_grant && host_req) |=> host_grant);

    assert_float_before_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |=> !host_grant);

    assert_hold_midcycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && !bus_cyc_end) |=> (state_q == ST_BUSY && $stable(master_q)));

    assert_pick_found_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_pick) == (win != '0));

endmodule

// File: tb/test_mp_bus_arbiter.sv
`timescale 1ns/1ps
module test_mp_bus_arbiter;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] cfg_id;
    logic       cfg_rotate, core_req, core_prio, cpa_in, host_req, suspend, bus_cyc_end;
    logic [5:0] br_in;
    logic       br_out, cpa_out, host_grant, bus_oe, is_master, access_stall;

    always #2 clk = ~clk;

    mp_bus_arbiter i_mp_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .cfg_id(cfg_id), .cfg_rotate(cfg_rotate),
        .core_req(core_req), .core_prio(core_prio), .br_in(br_in), .br_out(br_out),
        .cpa_in(cpa_in), .cpa_out(cpa_out), .host_req(host_req), .host_grant(host_grant),
        .suspend(suspend), .bus_cyc_end(bus_cyc_end), .bus_oe(bus_oe),
        .is_master(is_master), .access_stall(access_stall)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    string master_tag = "R3";

    // Reference model state: 0 idle, 1 busy, 2 release, 3 host
    int m_st, m_m, m_last, m_id;
    bit m_susp;

    function automatic int pick(logic [5:0] r, int s);
        for (int k = 0; k < 6; k++) begin
            int idx = (s + k) % 6;
            if (r[idx]) return idx + 1;
        end
        return 0;
    endfunction

    function automatic bit m_valid();
        return (m_id >= 1 && m_id <= 6);
    endfunction

    task automatic model_step();
        logic [5:0] r, mb, lo;
        int w;
        bit solo, drop, hi;
        solo = !m_valid();
        r = br_in;
        if (!solo) r[m_id-1] = core_req;
        mb = '0; lo = '0;
        for (int i = 0; i < 6; i++) begin
            mb[i] = (m_m == i + 1);
            lo[i] = (i + 1 < m_m);
        end
        w = pick(r & ~mb, cfg_rotate ? (m_last % 6) : 0);
        drop = ((r & mb) == 0);
        hi = !cfg_rotate && ((r & lo) != 0);
        case (m_st)
            0, 3: begin
                if (host_req) m_st = 3;
                else if (solo) m_st = 1;
                else if (w != 0) begin m_st = 1; m_m = w; m_last = w; end
                else begin m_st = 0; m_m = 0; end
            end
            1: begin
                if (bus_cyc_end) begin
                    if (host_req) begin m_st = 2; m_m = 0; end
                    else if (!solo && (drop || hi || cpa_in)) begin
                        if (w != 0) begin m_m = w; m_last = w; end
                        else begin m_st = 0; m_m = 0; end
                    end
                end
            end
            default: m_st = 3;
        endcase
        m_susp = suspend;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit em;
        em = (m_st == 1) && (!m_valid() || m_m == m_id);
        chk(is_master, em, master_tag, "is_master");
        chk(bus_oe, em && !m_susp, "R7", "bus_oe");
        chk(host_grant, m_st == 3, "R5", "host_grant");
        chk(br_out, m_valid() && core_req, "R2", "br_out");
        chk(cpa_out, m_valid() && core_req && core_prio && !em, "R10", "cpa_out");
        chk(access_stall, em && core_req && m_susp, "R7", "access_stall");
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset(input int id, input bit rot);
        rst_n = 1'b0; cfg_id = 3'(id); cfg_rotate = rot;
        core_req = 0; core_prio = 0; cpa_in = 0; host_req = 0;
        suspend = 0; bus_cyc_end = 0; br_in = '0;
        repeat (3) @(posedge clk);
        m_st = 0; m_m = 0; m_last = 0; m_id = id; m_susp = 0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(is_master, 1'b0, "R1", "is_master after reset");
        chk(bus_oe, 1'b0, "R1", "bus_oe after reset");
        chk(host_grant, 1'b0, "R1", "host_grant after reset");
        chk(access_stall, 1'b0, "R1", "access_stall after reset");
    endtask

    task automatic random_phase(input int id, input bit rot, input int n);
        do_reset(id, rot);
        for (int c = 0; c < n; c++) begin
            if ($urandom % 8 == 0) core_req = ~core_req;
            core_prio = 1'($urandom % 2);
            for (int i = 0; i < 6; i++) if ($urandom % 10 == 0) br_in[i] = ~br_in[i];
            if (host_req) begin
                if ($urandom % 6 == 0) host_req = 0;
            end else if ($urandom % 40 == 0) host_req = 1;
            cpa_in = ($urandom % 12 == 0);
            suspend = ($urandom % 10 == 0);
            bus_cyc_end = 1'($urandom % 2);
            cfg_id = 3'($urandom % 8);
            cyc();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);

        // Directed, fixed priority, ID 3
        do_reset(3, 0);
        core_req = 1; cyc();
        chk(is_master, 1'b1, "R3", "lone requester wins");
        br_in[0] = 1; bus_cyc_end = 0; cyc();
        chk(is_master, 1'b1, "R4", "no preemption mid-cycle");
        bus_cyc_end = 1; cyc();
        chk(is_master, 1'b0, "R4", "lower ID preempts at cycle end");

        // Directed, rotating priority, ID 3
        do_reset(3, 1);
        core_req = 1; cyc();
        chk(is_master, 1'b1, "R3", "rotating first grant");
        br_in[0] = 1; bus_cyc_end = 1; cyc();
        chk(is_master, 1'b1, "R4", "rotating ignores lower ID");
        br_in[4] = 1; cpa_in = 1; cyc();
        chk(is_master, 1'b0, "R6", "core priority preempts");
        chk(bus_oe, 1'b0, "R6", "bus released on preemption");
        cpa_in = 0; br_in = '0; cyc();
        chk(is_master, 1'b1, "R3", "regain after ID5 drops");

        // Host handshake
        host_req = 1; bus_cyc_end = 0; cyc();
        chk(bus_oe, 1'b1, "R5", "master keeps bus until cycle end");
        bus_cyc_end = 1; cyc();
        chk(bus_oe, 1'b0, "R5", "float cycle oe");
        chk(host_grant, 1'b0, "R5", "float cycle grant");
        cyc();
        chk(host_grant, 1'b1, "R5", "grant after float");
        cyc(); cyc();
        chk(host_grant, 1'b1, "R5", "grant held");
        host_req = 0; cyc();
        chk(host_grant, 1'b0, "R5", "grant dropped");
        chk(is_master, 1'b1, "R5", "bus returned");

        // ID change after reset ignored
        cfg_id = 3'd5; core_req = 0; cyc();
        chk(is_master, 1'b0, "R9", "idle after drop");
        core_req = 1; cyc();
        chk(is_master, 1'b1, "R9", "still ID 3");

        // Suspend
        suspend = 1; bus_cyc_end = 0; cyc();
        chk(bus_oe, 1'b0, "R7", "suspend floats bus");
        chk(access_stall, 1'b1, "R7", "access stalls");
        suspend = 0; cyc();
        chk(bus_oe, 1'b1, "R7", "bus back after suspend");

        // Single processor
        do_reset(0, 0);
        cyc();
        chk(is_master, 1'b1, "R8", "solo owns bus");
        core_req = 1; br_in = 6'h3f; bus_cyc_end = 1; cyc();
        chk(br_out, 1'b0, "R8", "solo drives no request");
        chk(is_master, 1'b1, "R8", "solo ignores others");

        // Random phases
        random_phase(3, 0, 3000);
        random_phase(3, 1, 3000);
        random_phase(6, 1, 3000);
        random_phase(1, 0, 2000);
        master_tag = "R8";
        random_phase(0, 0, 2000);

        finish_run();
    end

endmodule